// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns the one-bit output stream of a sigma-delta modulator into signed 16-bit conversion words. Each modulator bit, qualified by a sample strobe, is read as +1 or -1 and passed through three running-sum stages. Then, once per output period, three differencing stages act on that running sum. The length of the output period, in modulator samples, is picked by a 2-bit rate code. It sets where the first response notch falls; the notches then repeat at multiples of the output rate.

Every time the filter restarts, all of its stored state is cleared. A restart comes from reset, from a synchronisation pulse, or from a new rate code. After a restart the data-ready strobe stays low until the filter has gone through enough output periods to settle. That is three periods after a reset or sync, and four after a rate change. A settled result is scaled by the reciprocal of the period length cubed, clipped to 16 bits, and sent out together with a one-clock data-ready pulse. In the target system the modulator strobe comes once every 128 master clocks. The block itself does not depend on that spacing.

Top module: `sinc3_decim`

## Requirements
- R1: The rate code selects the samples per output period. Code 2'b00 gives 384, 2'b01 gives 320, 2'b10 gives 77 and 2'b11 gives 38. One filtered value is formed on every such count of accepted strobes after a restart.
- R2: With x = +1 for bit 1 and x = -1 for bit 0, the filtered value is y = sum over k of h[k]*x[n-k]. Here x[n] is the newest accepted sample and h is three length-R boxcars convolved together. Samples from before the last restart count as zero.
- R3: The result is floor(y*K / 2^32) clipped to the range -32768..32767, where K = floor(2^47 / R^3). An all-ones stream therefore settles to 32767 and an all-zeros stream to -32768.
- R4: The data-ready pulse is high for exactly one clock. It arrives two clocks after the strobe that ends the output period, with the matching result present in that same clock.
- R5: A synchronisation pulse clears the filter. The first data-ready after it belongs to the third output period, and there is no data-ready in the clock that follows the pulse.
- R6: A change of the rate code clears the filter. The first data-ready after it belongs to the fourth output period of the new rate.
- R7: Synchronous reset drives result to 0 and data-ready low, and then restarts the filter the same way a sync pulse does.
- R8: A modulator strobe that comes in the same clock as a sync pulse is thrown away.
- R9: The result holds its value in every clock in which data-ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_stb | input | 1 | Modulator sample strobe, one clock wide |
| mod_bit | input | 1 | Modulator bit, sampled when mod_stb is high |
| rate_sel | input | 2 | Rate code that selects the samples per output period |
| sync_req | input | 1 | Synchronisation pulse that clears the filter |
| result | output | 16 | Signed conversion result |
| drdy | output | 1 | One-clock data-ready pulse for a settled result |

## Verification
The hardest cases to reach from the ports are the restart corners. One is the first settled output after a restart, where the state left over from before the restart must already be fully gone. The other is a strobe arriving in the same clock as a sync pulse. The bench keeps a sample-accurate model of the triple-boxcar response, which it rebuilds on every restart. It compares every data-ready word with that model, and any data-ready pulse that comes before the settling count is reported as unexpected. Rate changes are made both at period boundaries and in the middle of a period. A sync is also issued in the same clock as a strobe. Strobe spacing and bit density are random.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

   typedef enum logic [1:0] {
      RATE_C0 = 2'b00,
      RATE_C1 = 2'b01,
      RATE_C2 = 2'b10,
      RATE_C3 = 2'b11
   } rate_code_e;

   localparam logic [2:0] HOLD_SYNC = 3'd3;
   localparam logic [2:0] HOLD_RATE = 3'd4;

   function automatic longint unsigned ratio_pow(input int unsigned ratio,
                                                 input int unsigned order);
      longint unsigned p;
      p = 1;
      for (int i = 0; i < int'(order); i++) p = p * longint'(ratio);
      return p;
   endfunction

   // reciprocal of the DC gain, scaled by 2^pw
   function automatic longint unsigned recip_gain(input int unsigned ratio,
                                                  input int unsigned order,
                                                  input int unsigned pw);
      return (64'd1 << pw) / ratio_pow(ratio, order);
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int unsigned min4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      if (d < m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
   parameter int ORDER = 3,
   parameter int ACC_W = 28
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             din,
   output logic [ACC_W-1:0] tail
);
   logic [ACC_W-1:0] nxt [ORDER];
   logic [ACC_W-1:0] x_val;

   assign x_val = din ? ACC_W'(1) : '1;

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] acc_r;
      if (g == 0) begin : g_head
         assign nxt[g] = acc_r + x_val;
      end else begin : g_body
         assign nxt[g] = acc_r + nxt[g-1];
      end
      always_ff @(posedge clk) begin
         if (clr)     acc_r <= '0;
         else if (en) acc_r <= nxt[g];
      end
   end

   assign tail = nxt[ORDER-1];
endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
   parameter int ORDER = 3,
   parameter int ACC_W = 28
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             en,
   input  logic             keep,
   input  logic [ACC_W-1:0] din,
   output logic [ACC_W-1:0] y_q,
   output logic             y_vld
);
   logic [ACC_W-1:0] dif [ORDER];

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] prev_r;
      logic [ACC_W-1:0] src;
      if (g == 0) begin : g_head
         assign src = din;
      end else begin : g_body
         assign src = dif[g-1];
      end
      assign dif[g] = src - prev_r;
      always_ff @(posedge clk) begin
         if (clr)     prev_r <= '0;
         else if (en) prev_r <= src;
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         y_vld <= 1'b0;
         y_q   <= '0;
      end else begin
         y_vld <= en & keep;
         if (en) y_q <= dif[ORDER-1];
      end
   end
endmodule

// File: rtl/sinc3_ctrl.sv
module sinc3_ctrl
   import sinc3_pkg::*;
#(
   parameter int              RATIO_0 = 384,
   parameter int              RATIO_1 = 320,
   parameter int              RATIO_2 = 77,
   parameter int              RATIO_3 = 38,
   parameter int              CNT_W   = 9,
   parameter int              KW      = 32,
   parameter longint unsigned GAIN_0  = 1,
   parameter longint unsigned GAIN_1  = 1,
   parameter longint unsigned GAIN_2  = 1,
   parameter longint unsigned GAIN_3  = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    rate_sel,
   input  logic          sync_req,
   input  logic          mod_stb,
   output logic          restart,
   output logic          take,
   output logic          dump,
   output logic          keep,
   output logic [KW-1:0] gain
);
   rate_code_e       rate_q;
   logic [CNT_W-1:0] phase_q;
   logic [CNT_W-1:0] last_phase;
   logic [2:0]       seen_q;
   logic [2:0]       need_q;
   logic             rate_moved;

   assign rate_moved = rate_code_e'(rate_sel) != rate_q;
   assign restart    = rst | sync_req | rate_moved;
   assign take       = mod_stb & ~restart;

   always_comb begin
      unique case (rate_q)
         RATE_C0: begin last_phase = CNT_W'(RATIO_0 - 1); gain = KW'(GAIN_0); end
         RATE_C1: begin last_phase = CNT_W'(RATIO_1 - 1); gain = KW'(GAIN_1); end
         RATE_C2: begin last_phase = CNT_W'(RATIO_2 - 1); gain = KW'(GAIN_2); end
         RATE_C3: begin last_phase = CNT_W'(RATIO_3 - 1); gain = KW'(GAIN_3); end
      endcase
   end

   assign dump = take & (phase_q == last_phase);
   assign keep = (seen_q + 3'd1) >= need_q;

   always_ff @(posedge clk) begin
      if (restart) begin
         rate_q  <= rate_code_e'(rate_sel);
         phase_q <= '0;
         seen_q  <= '0;
         need_q  <= (rate_moved & ~rst) ? HOLD_RATE : HOLD_SYNC;
      end else if (take) begin
         if (dump) begin
            phase_q <= '0;
            if (seen_q < HOLD_RATE) seen_q <= seen_q + 3'd1;
         end else begin
            phase_q <= phase_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sinc3_scale.sv
module sinc3_scale #(
   parameter int ACC_W = 28,
   parameter int KW    = 32,
   parameter int SH    = 32,
   parameter int OUT_W = 16
) (
   input  logic [ACC_W-1:0] y,
   input  logic [KW-1:0]    gain,
   output logic [OUT_W-1:0] q
);
   localparam int PW = ACC_W + KW + 1;
   localparam logic signed [PW-1:0] HI = {{(PW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = ~HI;

   logic signed [PW-1:0] ys;
   logic signed [PW-1:0] gs;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shf;

   assign ys   = PW'($signed(y));
   assign gs   = PW'($signed({1'b0, gain}));
   assign prod = ys * gs;
   assign shf  = prod >>> SH;

   always_comb begin
      if (shf > HI)      q = HI[OUT_W-1:0];
      else if (shf < LO) q = LO[OUT_W-1:0];
      else               q = shf[OUT_W-1:0];
   end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
   import sinc3_pkg::*;
#(
   parameter int RATIO_0 = 384,
   parameter int RATIO_1 = 320,
   parameter int RATIO_2 = 77,
   parameter int RATIO_3 = 38,
   parameter int ORDER   = 3,
   parameter int ACC_W   = 28,
   parameter int OUT_W   = 16,
   parameter int GSH     = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             mod_stb,
   input  logic             mod_bit,
   input  logic [1:0]       rate_sel,
   input  logic             sync_req,
   output logic [OUT_W-1:0] result,
   output logic             drdy
);
   localparam int unsigned MAX_R = max4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
   localparam int unsigned MIN_R = min4(RATIO_0, RATIO_1, RATIO_2, RATIO_3);
   localparam int          CNT_W = $clog2(MAX_R);
   localparam int          GPW   = GSH + OUT_W - 1;
   localparam longint unsigned GAIN_0 = recip_gain(RATIO_0, ORDER, GPW);
   localparam longint unsigned GAIN_1 = recip_gain(RATIO_1, ORDER, GPW);
   localparam longint unsigned GAIN_2 = recip_gain(RATIO_2, ORDER, GPW);
   localparam longint unsigned GAIN_3 = recip_gain(RATIO_3, ORDER, GPW);
   localparam longint unsigned GAIN_MAX = recip_gain(MIN_R, ORDER, GPW);
   localparam int          KW    = $clog2(GAIN_MAX + 1);

   if (ORDER < 1) begin : g_bad_order
      $error("sinc3_decim: ORDER must be at least 1");
   end
   if (MIN_R < 2) begin : g_bad_ratio
      $error("sinc3_decim: every ratio must be at least 2");
   end
   if (ACC_W < ORDER * $clog2(MAX_R) + 1) begin : g_bad_acc
      $error("sinc3_decim: ACC_W too small for the largest ratio");
   end
   if (GPW > 62) begin : g_bad_gsh
      $error("sinc3_decim: GSH + OUT_W too large for gain arithmetic");
   end

   logic             restart;
   logic             take;
   logic             dump;
   logic             keep;
   logic [KW-1:0]    gain;
   logic [ACC_W-1:0] integ_tail;
   logic [ACC_W-1:0] comb_y;
   logic             comb_vld;
   logic [OUT_W-1:0] scaled;

   sinc3_ctrl #(
      .RATIO_0 (RATIO_0), .RATIO_1 (RATIO_1),
      .RATIO_2 (RATIO_2), .RATIO_3 (RATIO_3),
      .CNT_W   (CNT_W),   .KW      (KW),
      .GAIN_0  (GAIN_0),  .GAIN_1  (GAIN_1),
      .GAIN_2  (GAIN_2),  .GAIN_3  (GAIN_3)
   ) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .rate_sel (rate_sel),
      .sync_req (sync_req),
      .mod_stb  (mod_stb),
      .restart  (restart),
      .take     (take),
      .dump     (dump),
      .keep     (keep),
      .gain     (gain)
   );

   sinc3_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
      .clk  (clk),
      .clr  (restart),
      .en   (take),
      .din  (mod_bit),
      .tail (integ_tail)
   );

   sinc3_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
      .clk   (clk),
      .clr   (restart),
      .en    (dump),
      .keep  (keep),
      .din   (integ_tail),
      .y_q   (comb_y),
      .y_vld (comb_vld)
   );

   sinc3_scale #(.ACC_W(ACC_W), .KW(KW), .SH(GSH), .OUT_W(OUT_W)) u_scale (
      .y    (comb_y),
      .gain (gain),
      .q    (scaled)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         drdy   <= 1'b0;
      end else begin
         drdy <= comb_vld & ~restart;
         if (comb_vld & ~restart) result <= scaled;
      end
   end
endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk #(
   parameter int RATIO_0 = 384,
   parameter int RATIO_1 = 320,
   parameter int RATIO_2 = 77,
   parameter int RATIO_3 = 38,
   parameter int OUT_W   = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             mod_stb,
   input logic [1:0]       rate_sel,
   input logic             sync_req,
   input logic [OUT_W-1:0] result,
   input logic             drdy
);
   logic [1:0]  rate_seen;
   logic [15:0] stb_cnt;
   logic        hold4;
   logic        moved;
   logic        rs;
   logic [31:0] ratio_now;
   logic [31:0] lim;

   assign moved = rate_sel != rate_seen;
   assign rs    = rst | sync_req | moved;

   always_comb begin
      case (rate_seen)
         2'b00:   ratio_now = 32'(RATIO_0);
         2'b01:   ratio_now = 32'(RATIO_1);
         2'b10:   ratio_now = 32'(RATIO_2);
         default: ratio_now = 32'(RATIO_3);
      endcase
   end

   assign lim = (hold4 ? 32'd4 : 32'd3) * ratio_now;

   always_ff @(posedge clk) begin
      if (rs) begin
         rate_seen <= rate_sel;
         stb_cnt   <= '0;
         hold4     <= moved & ~rst;
      end else if (mod_stb && stb_cnt != 16'hFFFF) begin
         stb_cnt <= stb_cnt + 16'd1;
      end
   end

   AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (rst)
      drdy |-> ({16'd0, stb_cnt} >= lim)); // R5

   AST_RATE_WINDOW: assert property (@(posedge clk) disable iff (rst)
      (drdy && hold4) |-> ({16'd0, stb_cnt} >= 32'd4 * ratio_now)); // R6

   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      drdy |=> !drdy); // R4

   AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (rst)
      sync_req |=> !drdy); // R5

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
      !drdy |-> $stable(result)); // R9

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!drdy && result == '0)); // R7
endmodule

bind sinc3_decim sinc3_decim_chk #(
   .RATIO_0 (RATIO_0), .RATIO_1 (RATIO_1),
   .RATIO_2 (RATIO_2), .RATIO_3 (RATIO_3),
   .OUT_W   (OUT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mod_stb  (mod_stb),
   .rate_sel (rate_sel),
   .sync_req (sync_req),
   .result   (result),
   .drdy     (drdy)
);

// File: tb/sinc3_decim_tb.sv
module sinc3_decim_tb;
   localparam int HN = 1152;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mod_stb = 1'b0;
   logic        mod_bit = 1'b0;
   logic [1:0]  rate_sel = 2'b00;
   logic        sync_req = 1'b0;
   logic [15:0] result;
   logic        drdy;

   int     n_chk = 0;
   int     n_fail = 0;
   longint expq[$];
   int     hist [HN];
   longint h [HN];
   int     hp = 0;
   int     cur_r = 384;
   int     phase = 0;
   int     outs = 0;
   int     need = 3;
   int     taps = 1;
   string  tag = "R7";
   int     pulses = 0;
   int     hold_bad = 0;
   logic   prev_drdy = 1'b0;
   logic [15:0] last_res = '0;
   bit     done = 1'b0;

   sinc3_decim u_dut (
      .clk      (clk),
      .rst      (rst),
      .mod_stb  (mod_stb),
      .mod_bit  (mod_bit),
      .rate_sel (rate_sel),
      .sync_req (sync_req),
      .result   (result),
      .drdy     (drdy)
   );

   always #4 clk = ~clk;

   function automatic int ratio_of(input logic [1:0] c);
      case (c)
         2'b00:   return 384;
         2'b01:   return 320;
         2'b10:   return 77;
         default: return 38;
      endcase
   endfunction

   function automatic longint scale_ref(input longint y, input int r);
      longint r3, k, v;
      r3 = longint'(r) * r * r;
      k  = (longint'(1) <<< 47) / r3;
      v  = (y * k) >>> 32;
      if (v > 32767)  v = 32767;
      if (v < -32768) v = -32768;
      return v;
   endfunction

   task automatic check(input string req, input longint act, input longint exp_v);
      n_chk++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   task automatic model_restart(input int nd, input int r);
      longint box2 [HN];
      cur_r = r; need = nd; phase = 0; outs = 0; hp = 0;
      taps = 3 * r - 2;
      for (int i = 0; i < HN; i++) begin hist[i] = 0; h[i] = 0; box2[i] = 0; end
      for (int j = 0; j < 2 * r - 1; j++)
         box2[j] = (j + 1 < 2 * r - 1 - j) ? longint'(j + 1) : longint'(2 * r - 1 - j);
      for (int k = 0; k < taps; k++)
         for (int j = (k - r + 1 > 0 ? k - r + 1 : 0); j <= k && j < 2 * r - 1; j++)
            h[k] += box2[j];
   endtask

   task automatic model_sample(input bit b);
      longint y;
      hp = (hp + 1) % HN;
      hist[hp] = b ? 1 : -1;
      phase++;
      if (phase == cur_r) begin
         phase = 0;
         outs++;
         y = 0;
         for (int k = 0; k < taps; k++) y += h[k] * hist[(hp - k + HN) % HN];
         if (outs >= need) expq.push_back(scale_ref(y, cur_r));
      end
   endtask

   task automatic strobe(input bit b, input bit with_sync);
      @(negedge clk);
      mod_stb = 1'b1; mod_bit = b; sync_req = with_sync;
      if (with_sync) model_restart(3, cur_r);
      else           model_sample(b);
      @(negedge clk);
      mod_stb = 1'b0; sync_req = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   task automatic run_bits(input int n, input int dens);
      for (int i = 0; i < n; i++) strobe(($urandom % 100) < dens, 1'b0);
   endtask

   task automatic do_sync();
      @(negedge clk); sync_req = 1'b1; model_restart(3, cur_r);
      @(negedge clk); sync_req = 1'b0;
   endtask

   task automatic set_rate(input logic [1:0] c);
      @(negedge clk); rate_sel = c; model_restart(4, ratio_of(c));
   endtask

   task automatic drain(input string req);
      repeat (6) @(negedge clk);
      check(req, expq.size(), 0);
      check("R9", hold_bad, 0);
      hold_bad = 0;
   endtask

   always @(negedge clk) begin
      if (!rst) begin
         if (drdy) begin
            longint e;
            pulses++;
            if (prev_drdy) begin
               n_chk++; n_fail++;
               $display("FAIL R4: actual drdy high two clocks expected 1");
            end
            if (expq.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL %s: actual drdy with %0d expected none", tag, $signed(result));
            end else begin
               e = expq.pop_front();
               check(tag, longint'($signed(result)), e);
            end
         end else if (result != last_res) begin
            hold_bad++;
         end
         last_res  = result;
         prev_drdy = drdy;
      end
   end

   initial begin
      #(190000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int p0;
      void'($urandom(32'd1234));
      model_restart(3, 384);
      repeat (4) @(negedge clk);
      check("R7", drdy, 0);
      check("R7", result, 0);
      rst = 1'b0;

      // R7: after reset, all ones at 384, first drdy on third period
      tag = "R7"; pulses = 0;
      run_bits(5 * 384, 100);
      drain("R7");
      check("R7", pulses, 3);
      check("R3", longint'($signed(last_res)), 32767);

      // R6: rate change to 38, random density
      tag = "R6"; pulses = 0;
      set_rate(2'b11);
      run_bits(8 * 38, 30);
      drain("R6");
      check("R6", pulses, 5);

      // R5: sync then all zeros
      tag = "R5"; pulses = 0;
      do_sync();
      run_bits(6 * 38, 0);
      drain("R5");
      check("R5", pulses, 4);
      check("R3", longint'($signed(last_res)), -32768);

      // R1: rate 77
      tag = "R1"; pulses = 0;
      set_rate(2'b10);
      run_bits(7 * 77, 70);
      drain("R1");
      check("R1", pulses, 4);

      // R2: rate 320, half density
      tag = "R2"; pulses = 0;
      set_rate(2'b01);
      run_bits(6 * 320, 50);
      drain("R2");
      check("R2", pulses, 3);

      // R8: sync in the same clock as a strobe
      tag = "R8"; pulses = 0;
      run_bits(100, 60);
      strobe(1'b1, 1'b1);
      run_bits(4 * 320, 20);
      drain("R8");
      check("R8", pulses, 2);

      // R6: rate change in the middle of a period
      tag = "R6"; pulses = 0;
      set_rate(2'b11);
      run_bits(50, 90);
      set_rate(2'b10);
      run_bits(6 * 77, 40);
      drain("R6");
      check("R6", pulses, 3);

      // R2: random rates and densities
      for (int i = 0; i < 4; i++) begin
         logic [1:0] c;
         tag = "R2"; pulses = 0;
         c = 2'($urandom_range(0, 3));
         if (c == rate_sel) do_sync(); else set_rate(c);
         p0 = need;
         run_bits((need + 2) * cur_r, $urandom_range(0, 100));
         drain("R2");
         check("R2", pulses, 3);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule